// File: doc/BRIEF.md
# Message-to-Wishbone Mailbox Bridge

This block joins a 64-bit register-message stream driven by a host to a 32-bit Wishbone slave port serving a local processor. A host write into one of two posting pages queues a request for the processor: either a write that the processor must consume, or a read that the processor must answer. The processor sees the request through a data register, a control register and a status register. It answers a read by loading the data register and then writing the control register with the response flag set. The host learns that the answer has arrived by polling a status page, and then fetches the value from a data page.

In the other direction the processor builds its own write or read messages for the host. It loads the data register and then writes a control word carrying a write or a read flag. Each such message waits in an outbound queue until the host stream takes it. Read responses coming back from the host clear the outstanding-read flag and leave their data in a receive register. Replies to host reads take the output before queued processor messages.

Top module: `mbx_bridge`

## Requirements
- R1: Wishbone offsets are decoded on address bits 3:2: 0x0 data, 0x4 control, 0x8 received response data, 0xC status. A strobe seen while ack is low is performed at that edge, and ack is high for exactly the following cycle, with read data valid in that cycle.
- R2: Host message layout: bit 63 response, bit 62 write, bit 61 read, bits 51:32 address, bits 31:0 data. A host write to page 0x7B (address bits 19:12) with data D sets status bit 1. The data register then reads D and control reads 0x40000000 OR address bits 15:0. The host write wins over a processor data write in the same cycle.
- R3: A host write to page 0x6A posts a read request. It sets status bits 1 and 2, and control reads 0x20000000 OR address bits 15:0.
- R4: A processor read of control clears status bit 1. A request posted in the same cycle keeps bit 1 set and replaces the control word. That read returns the old control word.
- R5: A processor control write with bit 31 set clears status bit 2 and captures the data register for the host. A host read of page 0x6A replies {31'b0, status bit 2}, and a host read of page 0x7A replies the captured value. Each reply has bit 63 set, echoes the address and carries the value in bits 31:0.
- R6: A control write with bit 31 clear and bit 30 set queues an outbound message whose upper half is the written control word and whose lower half is the data register. Writing only the data register queues nothing.
- R7: A control write with bits 31:30 clear and bit 29 set queues a read message the same way and sets status bit 0. An inbound response message clears bit 0 and its data reads at offset 0x8. A read issued in the same cycle as a response arrives leaves bit 0 set.
- R8: The outbound queue holds 64 messages. Status bit 4 is set while it is full, and requests made while full are dropped without setting bit 0. Bit 4 clears once one message is taken.
- R9: Host reads of other pages reply 0. Host writes to other pages change no status, data or control value.
- R10: A host read reply is presented before any queued message. While the output is valid and not taken, hout_data holds and hin_ready is low.
- R11: After reset, status reads 0, hout_valid and wb_ack are low and hin_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 16 | Wishbone byte address |
| wb_wdat | input | 32 | Wishbone write data |
| wb_ack | output | 1 | Wishbone acknowledge |
| wb_rdat | output | 32 | Wishbone read data |
| hin_data | input | 64 | Inbound host message |
| hin_valid | input | 1 | Inbound message valid |
| hin_ready | output | 1 | Inbound message accepted |
| hout_data | output | 64 | Outbound message to host |
| hout_valid | output | 1 | Outbound message valid |
| hout_ready | input | 1 | Host takes outbound message |

## Verification
Two pairs of functions can meet at one clock edge. In the first, a processor read of control consumes a request in the same cycle that a new host request is posted. In the second, a processor read request is issued in the same cycle that a host read response arrives. The bench drives the Wishbone strobe and the inbound message in the same cycle to provoke each pair. It then judges the outcome at the ports: the value returned by the control read, the status word and the receive register afterwards, all of which must show that the setting event won. Random processor write and read traffic is compared message by message against a model queue in the bench.

// File: rtl/mbx_pkg.sv
// Package: shared message layout, status bit positions and control flags
// for the mailbox bridge. Assumes a 64-bit host message built from a
// 32-bit control half and a 32-bit data half.
package mbx_pkg;
    localparam int WORD_W = 32;
    localparam int MSG_W  = 2 * WORD_W;
    localparam int HADR_W = 20;

    // Host message fields; position is decoded by the host transport.
    typedef struct packed {
        logic              rsp;
        logic              wr;
        logic              rd;
        logic              half;
        logic [7:0]        pad;
        logic [HADR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } host_msg_t;

    // Control word flags.
    localparam int CTL_RSP = 31;
    localparam int CTL_WR  = 30;
    localparam int CTL_RD  = 29;

    // Status bit positions.
    localparam int ST_LRD   = 0;
    localparam int ST_HREQ  = 1;
    localparam int ST_AWAIT = 2;
    localparam int ST_QFULL = 4;
endpackage

// File: rtl/mbx_fifo.sv
// Module: outbound request queue. Stores processor messages until the host
// stream takes them. Assumes DEPTH is a power of two; a push while full is
// dropped, a pop while empty is ignored.
module mbx_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_host_rx.sv
// Module: host-side receiver. Decodes inbound host messages into posting
// events and response arrivals, and builds the single reply to a host read.
// Assumes the top takes the reply before any queued message and that a
// stalled output blocks new inbound messages.
module mbx_host_rx
    import mbx_pkg::*;
#(
    parameter logic [7:0] REQ_PAGE   = 8'h6A,
    parameter logic [7:0] WREQ_PAGE  = 8'h7B,
    parameter logic [7:0] RDATA_PAGE = 8'h7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MSG_W-1:0]  hin_data,
    input  logic              hin_valid,
    output logic              hin_ready,
    input  logic              out_stall,
    input  logic              slot_take,
    input  logic              await_bit,
    input  logic [WORD_W-1:0] host_rdata,
    output logic              post_wr,
    output logic              post_rd,
    output logic [15:0]       post_addr,
    output logic [WORD_W-1:0] post_data,
    output logic              rsp_in,
    output logic [WORD_W-1:0] rsp_data,
    output logic              slot_v,
    output logic [MSG_W-1:0]  slot_msg
);
    host_msg_t         m;
    logic              acc, is_wr, is_rd;
    logic [7:0]        page;
    logic [WORD_W-1:0] reply_val;
    logic              unused_fields;

    assign m             = host_msg_t'(hin_data);
    assign unused_fields = ^{m.half, m.pad};
    assign page          = m.addr[19:12];
    assign hin_ready     = !slot_v && !out_stall;
    assign acc           = hin_valid && hin_ready;
    assign is_wr         = !m.rsp && m.wr;
    assign is_rd         = !m.rsp && !m.wr && m.rd;

    assign post_wr   = acc && is_wr && (page == WREQ_PAGE);
    assign post_rd   = acc && is_wr && (page == REQ_PAGE);
    assign post_addr = m.addr[15:0];
    assign post_data = m.data;
    assign rsp_in    = acc && m.rsp;
    assign rsp_data  = m.data;

    // Value returned to a host read, by page.
    always_comb begin
        if (page == REQ_PAGE)        reply_val = {{(WORD_W-1){1'b0}}, await_bit};
        else if (page == RDATA_PAGE) reply_val = host_rdata;
        else                         reply_val = '0;
    end

    // Reply slot: filled on an accepted host read, emptied when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v   <= 1'b0;
            slot_msg <= '0;
        end else if (acc && is_rd) begin
            slot_v   <= 1'b1;
            slot_msg <= {1'b1, 3'b000, 8'h00, m.addr, reply_val};
        end else if (slot_take) begin
            slot_v   <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_local_regs.sv
// Module: processor-side register file. Serves the Wishbone slave, keeps the
// data, control, receive and status state, and forms outbound messages.
// Assumes single-cycle acknowledge: a strobe is acted on only while ack is low.
module mbx_local_regs
    import mbx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [AW-1:0]     wb_adr,
    input  logic [WORD_W-1:0] wb_wdat,
    output logic              wb_ack,
    output logic [WORD_W-1:0] wb_rdat,
    input  logic              post_wr,
    input  logic              post_rd,
    input  logic [15:0]       post_addr,
    input  logic [WORD_W-1:0] post_data,
    input  logic              rsp_in,
    input  logic [WORD_W-1:0] rsp_data,
    input  logic              q_full,
    output logic              enq,
    output logic [MSG_W-1:0]  enq_msg,
    output logic              await_bit,
    output logic [WORD_W-1:0] host_rdata
);
    logic [WORD_W-1:0] data_q, ctrl_q, rx_q, status;
    logic              st_lrd, st_hreq;
    logic              acc, wr_data, wr_ctrl, rd_ctrl;
    logic              do_rsp, do_wr, do_rd;
    logic [1:0]        sel;
    logic              unused_adr;

    assign sel        = wb_adr[3:2];
    assign unused_adr = ^{wb_adr[AW-1:4], wb_adr[1:0]};
    assign acc        = wb_stb && !wb_ack;
    assign wr_data    = acc && wb_we && (sel == 2'd0);
    assign wr_ctrl    = acc && wb_we && (sel == 2'd1);
    assign rd_ctrl    = acc && !wb_we && (sel == 2'd1);

    assign do_rsp = wr_ctrl && wb_wdat[CTL_RSP];
    assign do_wr  = wr_ctrl && !wb_wdat[CTL_RSP] && wb_wdat[CTL_WR];
    assign do_rd  = wr_ctrl && !wb_wdat[CTL_RSP] && !wb_wdat[CTL_WR] && wb_wdat[CTL_RD];

    assign enq     = (do_wr || do_rd) && !q_full;
    assign enq_msg = {wb_wdat, data_q};

    assign status = {{(WORD_W-5){1'b0}}, q_full, 1'b0, await_bit, st_hreq, st_lrd};

    // Wishbone acknowledge and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack  <= 1'b0;
            wb_rdat <= '0;
        end else begin
            wb_ack <= acc;
            if (acc && !wb_we) begin
                case (sel)
                    2'd0:    wb_rdat <= data_q;
                    2'd1:    wb_rdat <= ctrl_q;
                    2'd2:    wb_rdat <= rx_q;
                    default: wb_rdat <= status;
                endcase
            end
        end
    end

    // Data register: a host post wins over a processor write.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (post_wr) data_q <= post_data;
        else if (wr_data) data_q <= wb_wdat;
    end

    // Pending host request word and its status flag; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            st_hreq <= 1'b0;
        end else if (post_wr) begin
            ctrl_q  <= {3'b010, 13'b0, post_addr};
            st_hreq <= 1'b1;
        end else if (post_rd) begin
            ctrl_q  <= {3'b001, 13'b0, post_addr};
            st_hreq <= 1'b1;
        end else if (rd_ctrl) begin
            st_hreq <= 1'b0;
        end
    end

    // Awaited local answer to a host read, and the captured answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            await_bit  <= 1'b0;
            host_rdata <= '0;
        end else begin
            if (post_rd)     await_bit <= 1'b1;
            else if (do_rsp) await_bit <= 1'b0;
            if (do_rsp)      host_rdata <= data_q;
        end
    end

    // Outstanding processor read and the received response data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_lrd <= 1'b0;
            rx_q   <= '0;
        end else begin
            if (do_rd && !q_full) st_lrd <= 1'b1;
            else if (rsp_in)      st_lrd <= 1'b0;
            if (rsp_in)           rx_q   <= rsp_data;
        end
    end
endmodule

// File: rtl/mbx_bridge.sv
// Module: top of the mailbox bridge. Wires the host receiver, the processor
// register file and the outbound queue, and merges host read replies with
// queued processor messages onto one output stream, replies first.
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int         WB_AW      = 16,
    parameter int         Q_DEPTH    = 64,
    parameter logic [7:0] REQ_PAGE   = 8'h6A,
    parameter logic [7:0] WREQ_PAGE  = 8'h7B,
    parameter logic [7:0] RDATA_PAGE = 8'h7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [WB_AW-1:0]  wb_adr,
    input  logic [WORD_W-1:0] wb_wdat,
    output logic              wb_ack,
    output logic [WORD_W-1:0] wb_rdat,
    input  logic [MSG_W-1:0]  hin_data,
    input  logic              hin_valid,
    output logic              hin_ready,
    output logic [MSG_W-1:0]  hout_data,
    output logic              hout_valid,
    input  logic              hout_ready
);
    logic              post_wr, post_rd, rsp_in;
    logic [15:0]       post_addr;
    logic [WORD_W-1:0] post_data, rsp_data, host_rdata;
    logic              slot_v, slot_take, await_bit, out_stall;
    logic [MSG_W-1:0]  slot_msg, q_head, enq_msg;
    logic              q_empty, q_full, q_pop, enq;

    // Output merge: the reply slot has priority over the queue head.
    assign hout_valid = slot_v || !q_empty;
    assign hout_data  = slot_v ? slot_msg : q_head;
    assign slot_take  = hout_ready && slot_v;
    assign q_pop      = hout_ready && !slot_v && !q_empty;
    assign out_stall  = hout_valid && !hout_ready;

    mbx_host_rx #(
        .REQ_PAGE   (REQ_PAGE),
        .WREQ_PAGE  (WREQ_PAGE),
        .RDATA_PAGE (RDATA_PAGE)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .hin_data   (hin_data),
        .hin_valid  (hin_valid),
        .hin_ready  (hin_ready),
        .out_stall  (out_stall),
        .slot_take  (slot_take),
        .await_bit  (await_bit),
        .host_rdata (host_rdata),
        .post_wr    (post_wr),
        .post_rd    (post_rd),
        .post_addr  (post_addr),
        .post_data  (post_data),
        .rsp_in     (rsp_in),
        .rsp_data   (rsp_data),
        .slot_v     (slot_v),
        .slot_msg   (slot_msg)
    );

    mbx_local_regs #(
        .AW (WB_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_stb     (wb_stb),
        .wb_we      (wb_we),
        .wb_adr     (wb_adr),
        .wb_wdat    (wb_wdat),
        .wb_ack     (wb_ack),
        .wb_rdat    (wb_rdat),
        .post_wr    (post_wr),
        .post_rd    (post_rd),
        .post_addr  (post_addr),
        .post_data  (post_data),
        .rsp_in     (rsp_in),
        .rsp_data   (rsp_data),
        .q_full     (q_full),
        .enq        (enq),
        .enq_msg    (enq_msg),
        .await_bit  (await_bit),
        .host_rdata (host_rdata)
    );

    mbx_fifo #(
        .WIDTH (MSG_W),
        .DEPTH (Q_DEPTH)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq),
        .push_data (enq_msg),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );
endmodule

// File: rtl/mbx_bridge_chk.sv
// Module: assertion checker for the mailbox bridge, bound to the top.
// Assumes it observes ports plus the queue full flag and pop strobe.
module mbx_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wb_stb,
    input logic        wb_ack,
    input logic [63:0] hin_data,
    input logic        hin_valid,
    input logic        hin_ready,
    input logic [63:0] hout_data,
    input logic        hout_valid,
    input logic        hout_ready,
    input logic        q_full,
    input logic        q_pop
);
    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb && !wb_ack |=> wb_ack); // R1
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack); // R1
    AST_REPLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hin_valid && hin_ready && !hin_data[63] && !hin_data[62] && hin_data[61]
        |=> hout_valid && hout_data[63]); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hout_valid && !hout_ready |=> hout_valid && $stable(hout_data)); // R10
    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        hout_valid && !hout_ready |-> !hin_ready); // R10
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && !q_pop |=> q_full); // R8
endmodule

bind mbx_bridge mbx_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_stb     (wb_stb),
    .wb_ack     (wb_ack),
    .hin_data   (hin_data),
    .hin_valid  (hin_valid),
    .hin_ready  (hin_ready),
    .hout_data  (hout_data),
    .hout_valid (hout_valid),
    .hout_ready (hout_ready),
    .q_full     (q_full),
    .q_pop      (q_pop)
);

// File: tb/tb_mbx_bridge.sv
// Bench: directed corner cases plus seeded random processor traffic, all
// checked against values computed by bench functions.
module tb_mbx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_stb = 1'b0, wb_we = 1'b0;
    logic [15:0] wb_adr = '0;
    logic [31:0] wb_wdat = '0;
    logic        wb_ack;
    logic [31:0] wb_rdat;
    logic [63:0] hin_data = '0;
    logic        hin_valid = 1'b0;
    logic        hin_ready;
    logic [63:0] hout_data;
    logic        hout_valid;
    logic        hout_ready = 1'b0;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [63:0] exp_m [64];

    always #4 clk = ~clk;

    mbx_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr), .wb_wdat(wb_wdat),
        .wb_ack(wb_ack), .wb_rdat(wb_rdat),
        .hin_data(hin_data), .hin_valid(hin_valid), .hin_ready(hin_ready),
        .hout_data(hout_data), .hout_valid(hout_valid), .hout_ready(hout_ready)
    );

    function automatic logic [63:0] f_hmsg(logic [2:0] kind, logic [19:0] a, logic [31:0] d);
        return {kind, 1'b0, 8'h00, a, d};  // kind = {rsp, wr, rd}
    endfunction
    function automatic logic [31:0] f_post_ctrl(bit is_wr, logic [19:0] a);
        return (is_wr ? 32'h4000_0000 : 32'h2000_0000) | {16'h0, a[15:0]};
    endfunction
    function automatic logic [63:0] f_reply(logic [19:0] a, logic [31:0] v);
        return {1'b1, 3'b000, 8'h00, a, v};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wb(bit we, logic [15:0] a, logic [31:0] d, output logic [31:0] rd);
        wb_stb = 1'b1; wb_we = we; wb_adr = a; wb_wdat = d;
        @(posedge clk); @(negedge clk);
        check("R1 ack", 64'(wb_ack), 64'd1);
        rd = wb_rdat;
        wb_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_send(logic [63:0] m);
        hin_data = m; hin_valid = 1'b1;
        while (!hin_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        hin_valid = 1'b0;
    endtask

    task automatic host_recv(output logic [63:0] m);
        while (!hout_valid) @(negedge clk);
        m = hout_data; hout_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        hout_ready = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [31:0] rd, d, ctl;
        logic [63:0] m;
        int n_exp;
        bit any_rd;
        void'($urandom(32'd2024));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 hout_valid", 64'(hout_valid), 64'd0);
        check("R11 hin_ready", 64'(hin_ready), 64'd1);
        wb(0, 16'hC, 0, rd); check("R11 status", 64'(rd), 64'h0);

        // R2 host write posting
        host_send(f_hmsg(3'b010, 20'h7B000, 32'h1234_5678));
        wb(0, 16'hC, 0, rd); check("R2 status", 64'(rd), 64'h2);
        wb(0, 16'h0, 0, rd); check("R2 data", 64'(rd), 64'h1234_5678);
        wb(0, 16'h4, 0, rd); check("R2 ctrl", 64'(rd), 64'(f_post_ctrl(1, 20'h7B000)));
        wb(0, 16'hC, 0, rd); check("R4 consumed", 64'(rd), 64'h0);

        // R3 / R5 host read posting and answer
        host_send(f_hmsg(3'b010, 20'h6A004, 32'h0));
        wb(0, 16'hC, 0, rd); check("R3 status", 64'(rd), 64'h6);
        wb(0, 16'h4, 0, rd); check("R3 ctrl", 64'(rd), 64'(f_post_ctrl(0, 20'h6A004)));
        wb(0, 16'hC, 0, rd); check("R4 status", 64'(rd), 64'h4);
        host_send(f_hmsg(3'b001, 20'h6A000, 32'h0)); host_recv(m);
        check("R5 pending reply", m, f_reply(20'h6A000, 32'h1));
        wb(1, 16'h0, 32'hDEAD_BEEF, rd);
        wb(1, 16'h4, 32'h8000_0000, rd);
        wb(0, 16'hC, 0, rd); check("R5 status", 64'(rd), 64'h0);
        host_send(f_hmsg(3'b001, 20'h6A000, 32'h0)); host_recv(m);
        check("R5 done reply", m, f_reply(20'h6A000, 32'h0));
        host_send(f_hmsg(3'b001, 20'h7A000, 32'h0)); host_recv(m);
        check("R5 data reply", m, f_reply(20'h7A000, 32'hDEAD_BEEF));

        // R9 unmapped pages
        host_send(f_hmsg(3'b010, 20'h12000, 32'h5));
        wb(0, 16'hC, 0, rd); check("R9 status", 64'(rd), 64'h0);
        wb(0, 16'h0, 0, rd); check("R9 data", 64'(rd), 64'hDEAD_BEEF);
        host_send(f_hmsg(3'b001, 20'h12340, 32'h0)); host_recv(m);
        check("R9 reply", m, f_reply(20'h12340, 32'h0));

        // R6 / R7 random processor traffic
        n_exp = 0; any_rd = 0;
        for (int i = 0; i < 20; i++) begin
            int kind = int'($urandom % 3);
            d = $urandom;
            wb(1, 16'h0, d, rd);
            if (kind < 2) begin
                ctl = (kind == 0 ? 32'h4000_0000 : 32'h2000_0000) | ($urandom & 32'h000F_FFFF);
                wb(1, 16'h4, ctl, rd);
                exp_m[n_exp] = {ctl, d}; n_exp++;
                if (kind == 1) any_rd = 1;
            end
        end
        wb(0, 16'hC, 0, rd); check("R7 status lrd", 64'(rd), 64'(any_rd));
        for (int i = 0; i < n_exp; i++) begin
            host_recv(m); check("R6 queued message", m, exp_m[i]);
        end
        check("R6 data-only emits nothing", 64'(hout_valid), 64'd0);
        host_send(f_hmsg(3'b100, 20'h0, 32'hC0FF_EE11));
        wb(0, 16'hC, 0, rd); check("R7 cleared", 64'(rd), 64'h0);
        wb(0, 16'h8, 0, rd); check("R7 rx data", 64'(rd), 64'hC0FF_EE11);

        // R7 collision: read issue with response arrival
        wb(1, 16'h0, 32'h0BAD_F00D, rd);
        wb_stb = 1; wb_we = 1; wb_adr = 16'h4; wb_wdat = 32'h2000_0123;
        hin_data = f_hmsg(3'b100, 20'h0, 32'h0000_A5A5); hin_valid = 1;
        @(posedge clk); @(negedge clk);
        wb_stb = 0; hin_valid = 0;
        @(negedge clk);
        wb(0, 16'hC, 0, rd); check("R7 set wins", 64'(rd), 64'h1);
        wb(0, 16'h8, 0, rd); check("R7 rx collide", 64'(rd), 64'hA5A5);
        host_recv(m); check("R7 read message", m, {32'h2000_0123, 32'h0BAD_F00D});
        host_send(f_hmsg(3'b100, 20'h0, 32'h1));

        // R4 collision: control read consume with new post
        host_send(f_hmsg(3'b010, 20'h7B010, 32'h11));
        wb_stb = 1; wb_we = 0; wb_adr = 16'h4;
        hin_data = f_hmsg(3'b010, 20'h6A020, 32'h0); hin_valid = 1;
        @(posedge clk); @(negedge clk);
        rd = wb_rdat; wb_stb = 0; hin_valid = 0;
        @(negedge clk);
        check("R4 old word", 64'(rd), 64'(f_post_ctrl(1, 20'h7B010)));
        wb(0, 16'hC, 0, rd); check("R4 set wins", 64'(rd), 64'h6);
        wb(0, 16'h4, 0, rd); check("R4 new word", 64'(rd), 64'(f_post_ctrl(0, 20'h6A020)));
        wb(1, 16'h4, 32'h8000_0000, rd);
        wb(0, 16'hC, 0, rd); check("R5 cleared", 64'(rd), 64'h0);

        // R8 queue full
        wb(1, 16'h0, 32'h77, rd);
        for (int i = 0; i < 64; i++) wb(1, 16'h4, 32'h2000_0000 | 32'(i), rd);
        wb(1, 16'h4, 32'h2000_0FFF, rd);
        wb(0, 16'hC, 0, rd); check("R8 full status", 64'(rd), 64'h11);
        host_recv(m); check("R8 first", m, {32'h2000_0000, 32'h77});
        wb(0, 16'hC, 0, rd); check("R8 full cleared", 64'(rd), 64'h1);
        for (int i = 1; i < 64; i++) begin
            host_recv(m); check("R8 order", m, {32'h2000_0000 | 32'(i), 32'h77});
        end
        check("R8 dropped", 64'(hout_valid), 64'd0);
        host_send(f_hmsg(3'b100, 20'h0, 32'h2));

        // R10 stall and reply priority
        wb(1, 16'h0, 32'h55, rd);
        wb(1, 16'h4, 32'h4000_0001, rd);
        wb(1, 16'h4, 32'h4000_0002, rd);
        check("R10 blocked", 64'(hin_ready), 64'd0);
        hout_ready = 1; hin_data = f_hmsg(3'b001, 20'h7A000, 32'h0); hin_valid = 1;
        check("R10 head", hout_data, {32'h4000_0001, 32'h55});
        @(posedge clk); @(negedge clk);
        hin_valid = 0;
        check("R10 reply first", 64'(hout_data[63:32]), 64'({1'b1, 3'b000, 8'h00, 20'h7A000}));
        @(posedge clk); @(negedge clk);
        check("R10 next", hout_data, {32'h4000_0002, 32'h55});
        @(posedge clk); @(negedge clk);
        hout_ready = 0;
        check("R10 drained", 64'(hout_valid), 64'd0);

        done = 1'b1;
        report();
    end
endmodule